// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block decides when a DRAM device must be refreshed so that each row is recharged once per retention window. That window is nominally 64 ms. The block raises a refresh request toward the command arbiter and keeps it raised until the arbiter grants it. After every granted refresh it withholds permission to open rows for the refresh recovery time. If the arbiter leaves refreshes waiting, they pile up in a backlog counter. Once the backlog grows deep, an urgency flag tells the arbiter to stop postponing.

Two pacing schemes are available, chosen by a mode input. In spread mode, one refresh falls due at fixed intervals, so the refreshes are evenly distributed over the window. In block mode, the whole window's worth of refreshes falls due at once, once per window. The refreshes then go out back to back, each separated only by the recovery time. A thermal input marks the device as hot. While it is set, every reload of the pacing timer uses half the normal span, so refreshes come twice as often.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is held and right after it is released, refReq and refUrgent are 0 and actAllow is 1.
- R2: In spread mode (burstMode=0, hotFlag=0), the first refresh falls due REFI_CYC cycles after reset release. refReq goes high after the REFI_CYC-th rising edge. After that, one refresh falls due every REFI_CYC cycles, so granted refreshes are spaced REFI_CYC cycles apart.
- R3: In block mode (burstMode=1), REFS_PER_PERIOD refreshes fall due together every REFI_CYC*REFS_PER_PERIOD cycles. With refGrant held at 1, consecutive grants within one block are RFC_CYC+1 cycles apart.
- R4: A grant is the refGrant and refReq pair sampled high at a rising edge. After a grant, actAllow is 0 for exactly RFC_CYC cycles and then returns to 1. refReq stays 0 while actAllow is 0.
- R5: While hotFlag=1, each timer reload uses half the normal span: REFI_CYC/2 in spread mode and REFI_CYC*REFS_PER_PERIOD/2 in block mode. A change of hotFlag takes effect at the next reload.
- R6: refReq stays high until a grant is taken. Refreshes that fall due without a grant are counted. They are then issued one per RFC_CYC+1 cycles once grants resume.
- R7: In spread mode, refUrgent is 1 exactly while at least URGENT_LVL (default 8) refreshes are outstanding. It drops as soon as a grant brings the backlog below that level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstMode | input | 1 | 0: spread refreshes evenly, 1: issue them in a block once per window |
| hotFlag | input | 1 | Device is hot; halves the pacing span at each reload |
| refGrant | input | 1 | Arbiter accepts the pending refresh request |
| refReq | output | 1 | A refresh is outstanding and may be issued now |
| refUrgent | output | 1 | Spread-mode backlog has reached the urgency level |
| actAllow | output | 1 | Row activates are permitted (refresh recovery has elapsed) |

## Verification
The bench builds the block with REFI_CYC=20, REFS_PER_PERIOD=4, RFC_CYC=5 and URGENT_LVL=8. These values make an 80-cycle block window, and 40 cycles when hot. Because the recovery time is short, both back-to-back spacing and long gaps appear within a few hundred cycles. An eight-deep backlog builds up in 140 cycles of withheld grants, so the urgency threshold, its release and the draining of postponed refreshes are all reached quickly.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  // Strobes from the control half to the counters in the datapath half.
  typedef struct packed {
    logic reload;    // pacing timer expired, reload it
    logic addOne;    // one refresh falls due (spread mode)
    logic addBurst;  // a full window of refreshes falls due (block mode)
    logic take;      // arbiter granted the outstanding refresh
  } rfshStrobe_t;
endpackage

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic        burstMode,
  input  logic        refGrant,
  input  logic        intervalDone,
  input  logic        pendNonZero,
  input  logic        rfcIdle,
  input  logic        pendAtUrgent,
  output rfshStrobe_t strb,
  output logic        refReq,
  output logic        refUrgent
);
  always_comb begin
    // A request is only offered once the previous refresh has recovered.
    refReq        = pendNonZero && rfcIdle;
    strb.take     = refReq && refGrant;
    strb.reload   = intervalDone;
    strb.addOne   = intervalDone && !burstMode;
    strb.addBurst = intervalDone && burstMode;
    refUrgent     = !burstMode && pendAtUrgent;
  end
endmodule

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int unsigned REFI_CYC        = 3900,
  parameter int unsigned REFS_PER_PERIOD = 8192,
  parameter int unsigned RFC_CYC         = 35,
  parameter int unsigned URGENT_LVL      = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           burstMode,
  input  logic           hotFlag,
  input  rfshStrobe_t    strb,
  output logic           intervalDone,
  output logic           pendNonZero,
  output logic           rfcIdle,
  output logic           pendAtUrgent,
  output logic [$clog2(REFS_PER_PERIOD*2+URGENT_LVL*2+2)-1:0] pendCount
);
  localparam int unsigned PERIOD   = REFI_CYC * REFS_PER_PERIOD;
  localparam int unsigned CW       = $clog2(PERIOD + 1);
  localparam int unsigned RW       = $clog2(RFC_CYC + 1);
  localparam int unsigned PEND_MAX = REFS_PER_PERIOD + 2 * URGENT_LVL;
  localparam int unsigned SW       = $clog2(REFS_PER_PERIOD*2 + URGENT_LVL*2 + 2);

  logic [CW-1:0] intervalCnt;
  logic [CW-1:0] baseSpan;
  logic [CW-1:0] reloadSpan;
  logic [RW-1:0] rfcCnt;
  logic [SW-1:0] addAmt;
  logic [SW-1:0] pendSum;

  // Pacing timer: span picked by mode, halved while hot.
  always_comb begin
    baseSpan   = burstMode ? CW'(PERIOD) : CW'(REFI_CYC);
    reloadSpan = hotFlag ? (baseSpan >> 1) : baseSpan;
  end

  assign intervalDone = (intervalCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)            intervalCnt <= CW'(REFI_CYC - 1);
    else if (strb.reload) intervalCnt <= reloadSpan - CW'(1);
    else                  intervalCnt <= intervalCnt - CW'(1);
  end

  // Outstanding refresh backlog with saturation.
  always_comb begin
    if (strb.addBurst)    addAmt = SW'(REFS_PER_PERIOD);
    else if (strb.addOne) addAmt = SW'(1);
    else                  addAmt = '0;
    pendSum = pendCount + addAmt - SW'(strb.take);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      pendCount <= '0;
    else if (pendSum > SW'(PEND_MAX)) pendCount <= SW'(PEND_MAX);
    else                            pendCount <= pendSum;
  end

  assign pendNonZero  = (pendCount != '0);
  assign pendAtUrgent = (pendCount >= SW'(URGENT_LVL));

  // Recovery timer after each granted refresh.
  always_ff @(posedge clk) begin
    if (!rstN)               rfcCnt <= '0;
    else if (strb.take)      rfcCnt <= RW'(RFC_CYC);
    else if (rfcCnt != '0)   rfcCnt <= rfcCnt - RW'(1);
  end

  assign rfcIdle = (rfcCnt == '0);
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned REFI_CYC        = 3900,
  parameter int unsigned REFS_PER_PERIOD = 8192,
  parameter int unsigned RFC_CYC         = 35,
  parameter int unsigned URGENT_LVL      = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic burstMode,
  input  logic hotFlag,
  input  logic refGrant,
  output logic refReq,
  output logic refUrgent,
  output logic actAllow
);
  localparam int unsigned SW = $clog2(REFS_PER_PERIOD*2 + URGENT_LVL*2 + 2);

  rfshStrobe_t   strb;
  logic          intervalDone;
  logic          pendNonZero;
  logic          rfcIdle;
  logic          pendAtUrgent;
  logic [SW-1:0] pendCount;

  rfsh_ctrl u_ctrl (
    .burstMode    (burstMode),
    .refGrant     (refGrant),
    .intervalDone (intervalDone),
    .pendNonZero  (pendNonZero),
    .rfcIdle      (rfcIdle),
    .pendAtUrgent (pendAtUrgent),
    .strb         (strb),
    .refReq       (refReq),
    .refUrgent    (refUrgent)
  );

  rfsh_datapath #(
    .REFI_CYC        (REFI_CYC),
    .REFS_PER_PERIOD (REFS_PER_PERIOD),
    .RFC_CYC         (RFC_CYC),
    .URGENT_LVL      (URGENT_LVL)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .burstMode    (burstMode),
    .hotFlag      (hotFlag),
    .strb         (strb),
    .intervalDone (intervalDone),
    .pendNonZero  (pendNonZero),
    .rfcIdle      (rfcIdle),
    .pendAtUrgent (pendAtUrgent),
    .pendCount    (pendCount)
  );

  assign actAllow = rfcIdle;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int unsigned REFS_PER_PERIOD = 8192,
  parameter int unsigned URGENT_LVL      = 8
) (
  input logic clk,
  input logic rstN,
  input logic refReq,
  input logic refGrant,
  input logic actAllow,
  input logic refUrgent,
  input logic [$clog2(REFS_PER_PERIOD*2+URGENT_LVL*2+2)-1:0] pendCount
);
  localparam int unsigned PEND_MAX = REFS_PER_PERIOD + 2 * URGENT_LVL;

  // R4
  grant_blocks_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant) |=> !actAllow);

  // R4
  no_req_in_rfc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !actAllow |-> !refReq);

  // R6
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refGrant) |=> refReq);

  // R7
  urgent_has_backlog_chk: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> (pendCount != '0));

  // R6
  backlog_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= PEND_MAX);
endmodule

bind rfsh_sched rfsh_sched_chk #(
  .REFS_PER_PERIOD (REFS_PER_PERIOD),
  .URGENT_LVL      (URGENT_LVL)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .refReq    (refReq),
  .refGrant  (refGrant),
  .actAllow  (actAllow),
  .refUrgent (refUrgent),
  .pendCount (pendCount)
);

// File: tb/tb_rfsh_sched.sv
module tb_rfsh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int REFI = 20;
  localparam int REFS = 4;
  localparam int RFC  = 5;
  localparam int URG  = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic burstMode = 1'b0;
  logic hotFlag = 1'b0;
  logic refGrant = 1'b1;
  logic refReq, refUrgent, actAllow;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ncyc = 0;
  int lastGrant = 0;
  bit haveLast = 0;
  int grantCnt = 0;
  int bigCnt = 0;
  int smallCnt = 0;
  int rfcWatch = 0;
  bit endPending = 0;
  bit done = 0;
  int expQ[$];
  string tagQ[$];

  rfsh_sched #(
    .REFI_CYC (REFI), .REFS_PER_PERIOD (REFS), .RFC_CYC (RFC), .URGENT_LVL (URG)
  ) dut (
    .clk (clk), .rstN (rstN), .burstMode (burstMode), .hotFlag (hotFlag),
    .refGrant (refGrant), .refReq (refReq), .refUrgent (refUrgent), .actAllow (actAllow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expectGaps(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(gap);
      tagQ.push_back(tag);
    end
  endtask

  task automatic waitEmpty();
    while (expQ.size() != 0) @(posedge clk);
  endtask

  task automatic waitGrants(input int n);
    int g0;
    g0 = grantCnt;
    while (grantCnt < g0 + n) @(posedge clk);
  endtask

  task automatic waitBlockStart();
    int s0, b0;
    s0 = smallCnt;
    while (smallCnt == s0) @(posedge clk);
    b0 = bigCnt;
    while (bigCnt == b0) @(posedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Monitor: recovery window and grant spacing scoreboard.
  always @(negedge clk) begin
    if (rstN) begin
      ncyc++;
      if (rfcWatch > 0) begin
        chk(!actAllow && !refReq, "R4 recovery window", {30'd0, actAllow, refReq}, 0);
        rfcWatch--;
        if (rfcWatch == 0) endPending = 1;
      end else if (endPending) begin
        chk(actAllow, "R4 recovery end", int'(actAllow), 1);
        endPending = 0;
      end
      if (refReq && refGrant) begin
        int gap;
        gap = ncyc - lastGrant;
        if (haveLast) begin
          if (gap > RFC + 1) bigCnt++;
          else smallCnt++;
          if (expQ.size() != 0) begin
            int e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            chk(gap == e, t, gap, e);
          end
        end
        lastGrant = ncyc;
        haveLast = 1;
        grantCnt++;
        rfcWatch = RFC;
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!refReq && !refUrgent && actAllow, "R1 in reset", {29'd0, refReq, refUrgent, actAllow}, 1);
    rstN = 1'b1;
    #1;
    chk(!refReq && !refUrgent && actAllow, "R1 after release", {29'd0, refReq, refUrgent, actAllow}, 1);

    // R2: first request timing
    repeat (REFI - 1) @(negedge clk);
    chk(!refReq, "R2 no early request", int'(refReq), 0);
    @(negedge clk);
    chk(refReq, "R2 first request", int'(refReq), 1);

    // R2: spread mode spacing
    expectGaps(4, REFI, "R2 spread spacing");
    waitEmpty();

    // R5: hot spread mode
    @(posedge clk); #1 hotFlag = 1'b1;
    waitGrants(3);
    expectGaps(4, REFI / 2, "R5 hot spread spacing");
    waitEmpty();
    @(posedge clk); #1 hotFlag = 1'b0;
    waitGrants(3);

    // R6 and R7: withheld grants build a backlog
    waitGrants(1);
    #1 refGrant = 1'b0;
    @(negedge clk);
    while (!refReq) @(negedge clk);
    for (int j = 1; j <= 7 * REFI; j++) begin
      @(negedge clk);
      if (!refReq) chk(0, "R6 request held", int'(refReq), 1);
      if (j == 7 * REFI - 1) chk(!refUrgent, "R7 below level", int'(refUrgent), 0);
      if (j == 7 * REFI)     chk(refUrgent, "R7 at level", int'(refUrgent), 1);
    end
    chk(refReq, "R6 request held through backlog", int'(refReq), 1);
    @(posedge clk); #1 refGrant = 1'b1;
    waitGrants(1);
    expectGaps(2, RFC + 1, "R6 backlog drain spacing");
    @(negedge clk);
    chk(!refUrgent, "R7 drops after grant", int'(refUrgent), 0);
    waitEmpty();
    while (refReq || !actAllow) @(negedge clk);

    // R3: block mode
    @(posedge clk); #1 burstMode = 1'b1;
    waitBlockStart();
    expectGaps(REFS - 1, RFC + 1, "R3 block spacing");
    expectGaps(1, REFI * REFS - (REFS - 1) * (RFC + 1), "R3 block window");
    expectGaps(REFS - 1, RFC + 1, "R3 block spacing");
    waitEmpty();

    // R5: hot block mode
    @(posedge clk); #1 hotFlag = 1'b1;
    waitBlockStart();
    waitBlockStart();
    expectGaps(REFS - 1, RFC + 1, "R5 hot block spacing");
    expectGaps(1, REFI * REFS / 2 - (REFS - 1) * (RFC + 1), "R5 hot block window");
    expectGaps(REFS - 1, RFC + 1, "R5 hot block spacing");
    waitEmpty();
    chk(!refUrgent, "R7 no urgency in block mode", int'(refUrgent), 0);

    repeat (10) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule